// File: doc/BRIEF.md
# Sticky-Latch GPIO Controller

This block manages a 16-bit field of general-purpose pins through a small register window at even byte addresses. Software picks each pin's direction and its active level, and can ask for each pin to remember an event until software clears it. Pin events can be routed into a single combined interrupt. Two pins can be given to alternate signals instead of GPIO data. Pin 2 can carry the combined interrupt and pin 5 can carry a serial audio stream.

Input pins pass through a two-stage synchronizer. A pin's status is its synchronized level XNOR its polarity bit, so status reads 1 when the pin is at its active level. If the sticky bit for a pin is set, an active level sets a latch that holds until software writes 0 to that status bit. The interrupt is asserted while any status bit with wake-up enabled is 1. Software services the set bits and then checks whether the interrupt is still asserted. The register port is a plain single-cycle interface with no handshake: a write takes effect at the clock edge, and read data is registered, so it appears one edge after the address is presented.

Top module: `gpio_sticky_ctrl`

## Requirements
- R1: After reset the registers read as follows: direction 0xF83F (every pin an input), polarity 0xFFFF, sticky 0x0000, wake-up 0x0000, function-select 0x0024. No pin drives, and `irq` is low.
- R2: Fixed bits ignore writes. Direction bits 15..11 read 1 and bits 10..6 read 0. Polarity bits 13, 12 and 10..6 read 1. Sticky and wake-up bits 13, 12 and 10..6 read 0. In the function-select register only bit 2 and bit 5 are writable, and every other bit reads 0.
- R3: Pin status, read at offset 0x54, is the synchronized pin level XNOR the polarity bit (polarity 1 means active high, 0 means active low). A change at `pin_in` reaches status two clock edges later.
- R4: When a pin's sticky bit (offset 0x50) is 1, an active level lasting even one clock sets its status bit, and the bit stays 1 after the pin returns to inactive.
- R5: Writing 0 to a status bit clears that pin's sticky latch. Writing 1 never sets the latch.
- R6: `pin_oe` is 1 for pins 0..5 whose direction bit (offset 0x4C) is 0. A write to offset 0x54 updates the output data only for those pins, and the output data of input pins is unchanged.
- R7: `irq` is the OR over all pins of status AND the wake-up bit (offset 0x52).
- R8: When function-select bit 2 (offset 0x56) is 0, `pin_out[2]` carries `irq`. When bit 5 is 0, `pin_out[5]` carries `audio_in`. When a select bit is 1, that pin carries GPIO output data. The pin drives only if its direction bit is 0.
- R9: Reads from any address other than 0x4C, 0x4E, 0x50, 0x52, 0x54 and 0x56 return 0, and writes to such addresses change nothing.
- R10: Status bits 13, 12 and 10..6 always read 0, whatever the pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the address seen at the previous edge |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Pin output values, including the alternate signals |
| pin_oe | output | 16 | Per-pin output enable |
| audio_in | input | 1 | Serial audio source for pin 5 |
| irq | output | 1 | Combined interrupt |

## Verification
Each result has a known latency. A register write is visible at the pins, at `irq` and in later reads one edge after the write. Read data appears one edge after the address is presented. A pin level reaches status and `irq` after two edges. A sticky latch needs one edge more, but the status bit already shows the active level during that edge.

The bench drives inputs at falling edges. Read expectations go into a queue, and a monitor compares each one shortly after the rising edge that registers the read data. Pin and interrupt outputs are checked only after at least three idle cycles following a pin change, or at the falling edge right after a register write.

// File: rtl/gpio_sticky_pkg.sv
package gpio_sticky_pkg;
  localparam int unsigned PIN_W = 16;
  localparam int unsigned BADDR_W = 8;

  localparam logic [7:0] OFS_DIR  = 8'h4C;
  localparam logic [7:0] OFS_POL  = 8'h4E;
  localparam logic [7:0] OFS_LAT  = 8'h50;
  localparam logic [7:0] OFS_WAKE = 8'h52;
  localparam logic [7:0] OFS_STAT = 8'h54;
  localparam logic [7:0] OFS_ALT  = 8'h56;

  localparam logic [15:0] DIR_RW    = 16'h003F;
  localparam logic [15:0] DIR_FIX1  = 16'hF800;
  localparam logic [15:0] PIN_LIVE  = 16'hC83F;
  localparam logic [15:0] POL_FIX1  = 16'h37C0;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] lat_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] act;
  logic [W-1:0] lat_q;

  assign act = ~(lvl ^ pol);

  for (genvar i = 0; i < int'(W); i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      lat_q[i] <= 1'b0;
      else if (!lat_en[i] || clr[i])   lat_q[i] <= 1'b0;
      else if (act[i])                 lat_q[i] <= 1'b1;
    end

    p_sticky_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_en[i] && act[i] && !clr[i]) |=> lat_q[i]);
    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q[i] && lat_en[i] && !clr[i]) |=> lat_q[i]);
    p_sticky_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !lat_q[i]);
  end

  assign status = (act | lat_q) & LIVE;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_sticky_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [W-1:0] DIR_KEEP = '1,
  parameter logic [W-1:0] DIR_ONES = '0,
  parameter logic [W-1:0] LIVE     = '1,
  parameter logic [W-1:0] POL_ONES = '0,
  parameter int unsigned IRQ_PIN  = 2,
  parameter int unsigned AUD_PIN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      lat_q,
  output logic [W-1:0]      wake_q,
  output logic [W-1:0]      out_q,
  output logic              irq_gpio,
  output logic              aud_gpio,
  output logic [W-1:0]      stat_clr
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_LAT  = ADDR_W'(OFS_LAT);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(OFS_WAKE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_ALT  = ADDR_W'(OFS_ALT);

  logic [W-1:0] rd_next;
  logic [W-1:0] out_mask;
  logic         mapped;

  assign out_mask = ~dir_q & DIR_KEEP;
  assign stat_clr = (wr && addr == A_STAT) ? (~wdata & LIVE) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= DIR_KEEP | DIR_ONES;
      pol_q    <= LIVE | POL_ONES;
      lat_q    <= '0;
      wake_q   <= '0;
      out_q    <= '0;
      irq_gpio <= 1'b1;
      aud_gpio <= 1'b1;
    end else if (wr) begin
      unique case (addr)
        A_DIR:   dir_q  <= (wdata & DIR_KEEP) | DIR_ONES;
        A_POL:   pol_q  <= (wdata & LIVE) | POL_ONES;
        A_LAT:   lat_q  <= wdata & LIVE;
        A_WAKE:  wake_q <= wdata & LIVE;
        A_STAT:  out_q  <= (out_q & ~out_mask) | (wdata & out_mask);
        A_ALT: begin
          irq_gpio <= wdata[IRQ_PIN];
          aud_gpio <= wdata[AUD_PIN];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    mapped  = 1'b1;
    rd_next = '0;
    unique case (addr)
      A_DIR:   rd_next = dir_q;
      A_POL:   rd_next = pol_q;
      A_LAT:   rd_next = lat_q;
      A_WAKE:  rd_next = wake_q;
      A_STAT:  rd_next = status;
      A_ALT: begin
        rd_next[IRQ_PIN] = irq_gpio;
        rd_next[AUD_PIN] = aud_gpio;
      end
      default: mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

  p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped) |=> ($stable(dir_q) && $stable(pol_q) && $stable(lat_q)
                         && $stable(wake_q) && $stable(out_q)
                         && $stable(irq_gpio) && $stable(aud_gpio)));
  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> (rdata == '0));
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_STAT) |=> ((out_q & ~$past(out_mask)) == ($past(out_q) & ~$past(out_mask))));
endmodule

// File: rtl/gpio_sticky_ctrl.sv
module gpio_sticky_ctrl
  import gpio_sticky_pkg::*;
#(
  parameter int unsigned W           = PIN_W,
  parameter int unsigned ADDR_W      = BADDR_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IRQ_PIN     = 2,
  parameter int unsigned AUD_PIN     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  input  logic              audio_in,
  output logic              irq
);
  localparam logic [W-1:0] K_DIR  = W'(DIR_RW);
  localparam logic [W-1:0] K_DONE = W'(DIR_FIX1);
  localparam logic [W-1:0] K_LIVE = W'(PIN_LIVE);
  localparam logic [W-1:0] K_PONE = W'(POL_FIX1);

  logic [W-1:0] lvl_s, status, dir_q, pol_q, lat_q, wake_q, out_q, stat_clr;
  logic         irq_gpio, aud_gpio;

  gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl_s)
  );

  gpio_pin_event #(.W(W), .LIVE(K_LIVE)) u_event (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .pol(pol_q),
    .lat_en(lat_q), .clr(stat_clr), .status(status)
  );

  gpio_cfg_regs #(
    .W(W), .ADDR_W(ADDR_W), .DIR_KEEP(K_DIR), .DIR_ONES(K_DONE),
    .LIVE(K_LIVE), .POL_ONES(K_PONE), .IRQ_PIN(IRQ_PIN), .AUD_PIN(AUD_PIN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .status(status), .rdata(reg_rdata), .dir_q(dir_q), .pol_q(pol_q),
    .lat_q(lat_q), .wake_q(wake_q), .out_q(out_q), .irq_gpio(irq_gpio),
    .aud_gpio(aud_gpio), .stat_clr(stat_clr)
  );

  assign irq    = |(status & wake_q);
  assign pin_oe = ~dir_q & K_DIR;

  for (genvar i = 0; i < int'(W); i++) begin : g_pin
    if (i == int'(IRQ_PIN)) begin : g_irq
      assign pin_out[i] = irq_gpio ? out_q[i] : irq;
    end else if (i == int'(AUD_PIN)) begin : g_aud
      assign pin_out[i] = aud_gpio ? out_q[i] : audio_in;
    end else begin : g_gp
      assign pin_out[i] = out_q[i];
    end
  end

  p_irq_needs_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q == '0) |-> !irq);
  p_alt_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_gpio |-> (pin_out[IRQ_PIN] == irq));
  p_alt_aud_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !aud_gpio |-> (pin_out[AUD_PIN] == audio_in));
  p_dead_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~K_LIVE) == '0);
endmodule

// File: tb/gpio_sticky_ctrl_tb.sv
module gpio_sticky_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_out, pin_oe;
  logic        audio_in = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit rd_flag = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sbq[$];
  item_t it;

  always #2 clk = ~clk;

  gpio_sticky_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .audio_in(audio_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    item_t x;
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0; rd_flag = 1'b1;
    x.exp = exp; x.tag = tag;
    sbq.push_back(x);
    @(negedge clk);
    rd_flag = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rd_flag) begin
      #1;
      it = sbq.pop_front();
      chk(it.tag, reg_rdata, it.exp);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rd(8'h4C, 16'hF83F, "R1 dir");
    rd(8'h4E, 16'hFFFF, "R1 pol");
    rd(8'h50, 16'h0000, "R1 sticky");
    rd(8'h52, 16'h0000, "R1 wake");
    rd(8'h56, 16'h0024, "R1 fsel");
    rd(8'h54, 16'h0000, "R1 status");
    // R2 fixed bits
    wr(8'h4C, 16'h0000); rd(8'h4C, 16'hF800, "R2 dir zeros");
    wr(8'h4C, 16'hFFFF); rd(8'h4C, 16'hF83F, "R2 dir ones");
    wr(8'h4E, 16'h0000); rd(8'h4E, 16'h37C0, "R2 pol zeros");
    wr(8'h4E, 16'hFFFF);
    wr(8'h50, 16'hFFFF); rd(8'h50, 16'hC83F, "R2 sticky ones");
    wr(8'h50, 16'h0000);
    wr(8'h52, 16'hFFFF); rd(8'h52, 16'hC83F, "R2 wake ones");
    wr(8'h52, 16'h0000);
    wr(8'h56, 16'h0000); rd(8'h56, 16'h0000, "R2 fsel zeros");
    wr(8'h56, 16'hFFFF); rd(8'h56, 16'h0024, "R2 fsel ones");
    // R3 / R10 status polarity
    pin_in = 16'h0805; idle(3);
    rd(8'h54, 16'h0805, "R3 active high");
    pin_in = 16'hFFFF; idle(3);
    rd(8'h54, 16'hC83F, "R10 dead bits");
    wr(8'h4E, 16'h0000); idle(1);
    rd(8'h54, 16'h0000, "R3 active low high pins");
    pin_in = 16'h0000; idle(3);
    rd(8'h54, 16'hC83F, "R3 active low low pins");
    wr(8'h4E, 16'hFFFF); idle(1);
    rd(8'h54, 16'h0000, "R3 restore");
    // R7 interrupt
    wr(8'h52, 16'h0001);
    pin_in = 16'h0001; idle(3);
    chk("R7 irq enabled bit", {15'd0, irq}, 16'h0001);
    pin_in = 16'h0002; idle(3);
    chk("R7 irq other bit", {15'd0, irq}, 16'h0000);
    wr(8'h52, 16'h0003);
    chk("R7 irq after enable", {15'd0, irq}, 16'h0001);
    wr(8'h52, 16'h0000);
    pin_in = 16'h0000; idle(3);
    // R4 / R5 sticky
    wr(8'h50, 16'h0002);
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk); pin_in[1] = 1'b0;
    idle(4);
    rd(8'h54, 16'h0002, "R4 latched pulse");
    chk("R4 irq masked", {15'd0, irq}, 16'h0000);
    wr(8'h52, 16'h0002);
    chk("R7 irq from latch", {15'd0, irq}, 16'h0001);
    wr(8'h54, 16'hFFFF); idle(1);
    rd(8'h54, 16'h0002, "R5 write one keeps");
    wr(8'h54, 16'hFFFD); idle(1);
    rd(8'h54, 16'h0000, "R5 write zero clears");
    chk("R5 irq cleared", {15'd0, irq}, 16'h0000);
    wr(8'h54, 16'hFFFF); idle(1);
    rd(8'h54, 16'h0000, "R5 write one no set");
    // R6 output data
    wr(8'h4C, 16'h0030);
    chk("R6 oe", pin_oe, 16'h000F);
    wr(8'h54, 16'hFFFF);
    chk("R6 out written", pin_out, 16'h000F);
    wr(8'h4C, 16'h003F);
    chk("R6 oe off", pin_oe, 16'h0000);
    wr(8'h54, 16'h0000);
    chk("R6 input pins hold", pin_out, 16'h000F);
    wr(8'h4C, 16'h0030);
    wr(8'h54, 16'h0005);
    chk("R6 out rewrite", pin_out, 16'h0005);
    // R8 alternate functions
    wr(8'h56, 16'h0000);
    wr(8'h4C, 16'h0000);
    chk("R8 oe all", pin_oe, 16'h003F);
    chk("R8 pin2 irq low", {15'd0, pin_out[2]}, 16'h0000);
    audio_in = 1'b1; #1;
    chk("R8 pin5 audio", {15'd0, pin_out[5]}, 16'h0001);
    wr(8'h52, 16'h0001);
    pin_in = 16'h0001; idle(3);
    chk("R8 pin2 irq high", {15'd0, pin_out[2]}, 16'h0001);
    wr(8'h56, 16'h0024);
    pin_in = 16'h0000; idle(3);
    chk("R8 pin2 gpio", {15'd0, pin_out[2]}, 16'h0001);
    chk("R8 pin5 gpio", {15'd0, pin_out[5]}, 16'h0000);
    // R9 unmapped
    wr(8'h40, 16'hFFFF);
    rd(8'h40, 16'h0000, "R9 unmapped read");
    rd(8'h55, 16'h0000, "R9 odd address");
    rd(8'h4C, 16'hF800, "R9 dir untouched");
    rd(8'h52, 16'h0001, "R9 wake untouched");
    idle(3);
    finish_run();
  end
endmodule